// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that takes its whole job description from memory. Software gives it the address of the first descriptor and sets the run bit. The channel reads that six-word descriptor over a word-wide memory request port, then moves the requested number of bytes from the source address to the destination address. Each beat is one word read followed by one word write. When the descriptor is exhausted the channel follows its next-pointer, and it stops when that pointer holds the end-of-chain marker.

Each side of the transfer has its own address mode. An incrementing side advances by its access width after each beat. A fixed side keeps the same address and only moves when its peripheral request line is high. A small register window shows the configuration, source, destination, remaining byte count and parameter word of the descriptor being worked on. Software can hold the channel with a pause bit and abandon the chain with a stop. Three one-cycle event pulses report half-way progress, completion of each descriptor and completion of the whole chain to an interrupt block.

Top module: `dmac_ll_channel`

## Requirements
- R1: After reset every register reads 0, `mem_req` is low and no event pulses. The register window is selected by the word index `reg_idx`: 0 run, 1 pause, 2 first-descriptor address (reads back as written), 3 config, 4 source, 5 destination, 6 remaining count, 7 parameter.
- R2: Writing index 0 with bit 0 = 1 while idle starts the chain, and index 0 reads 1 while the channel is active. Writing index 0 with bit 0 = 0 returns the channel to idle on the next cycle, with no further memory requests and no event pulses.
- R3: A descriptor is fetched as six word reads from consecutive addresses, in this order: config, source, destination, byte length, parameter, next pointer. The first four and the parameter are loaded into registers 3, 4, 5, 6 and 7.
- R4: A next pointer equal to 0xFFFFF800 ends the chain and the channel goes idle. Any other value makes the channel fetch the descriptor at that address.
- R5: Config bits 4:0 hold the source request line, bit 5 the source fixed mode and bits 10:9 the source width code. Bits 20:16, 21 and 26:25 hold the same fields for the destination. Width code 0 means 1 byte, code 1 means 2 bytes and codes 2 and 3 mean 4 bytes.
- R6: After each beat an incrementing address advances by its side's width in bytes. A fixed-mode address does not change.
- R7: The remaining count starts at the byte length and drops by the source width after each beat, stopping at 0. The beat that reaches 0 ends the descriptor.
- R8: `evt_pkg` pulses for one cycle after each descriptor. `evt_queue` pulses in the same cycle after the last descriptor of the chain.
- R9: `evt_half` pulses once per descriptor, in the cycle after the beat that first brings the remaining count to half the length or less. A zero-length descriptor gives no half pulse.
- R10: While pause (index 1, bit 1) is set, the channel issues no new memory request and the remaining count holds. A beat already granted still completes. Clearing pause resumes the transfer where it stopped.
- R11: A descriptor of length 0 moves no data, pulses `evt_pkg` and goes on to its next pointer.
- R12: A data read from a fixed-mode source is requested only while `drq` of its source line is high. A write to a fixed-mode destination is requested only while `drq` of its destination line is high.
- R13: Writes to indices 3 to 7 have no effect on their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| drq | input | NUM_LINES | Peripheral request lines |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| evt_half | output | 1 | Half-transfer pulse |
| evt_pkg | output | 1 | Descriptor-complete pulse |
| evt_queue | output | 1 | Chain-complete pulse |

## Verification
Each kind of internal fault shows up at the ports in its own way. A sequencer that loses its fetch word index loads the wrong fields, which appears in the current registers as soon as the descriptor's fetch ends. A mis-tracked count shows as a wrong number of write beats, or as a half pulse sampled at the wrong remaining value, within one beat of the error. Address-step faults leave wrong final source and destination registers and misplaced destination data at the end of the descriptor. Pause, stop and request-line gating faults appear as memory requests in cycles where none may occur, and are observed within a few cycles.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned DESC_WORDS = 6;
    localparam logic [WORD_W-1:0] CHAIN_END = 32'hFFFF_F800;

    // descriptor word order in memory
    localparam logic [2:0] W_CFG  = 3'd0;
    localparam logic [2:0] W_SRC  = 3'd1;
    localparam logic [2:0] W_DST  = 3'd2;
    localparam logic [2:0] W_LEN  = 3'd3;
    localparam logic [2:0] W_PARA = 3'd4;
    localparam logic [2:0] W_NEXT = 3'd5;

    // register window word indices
    localparam logic [2:0] RI_RUN   = 3'd0;
    localparam logic [2:0] RI_PAUSE = 3'd1;
    localparam logic [2:0] RI_FIRST = 3'd2;
    localparam logic [2:0] RI_CFG   = 3'd3;
    localparam logic [2:0] RI_SRC   = 3'd4;
    localparam logic [2:0] RI_DST   = 3'd5;
    localparam logic [2:0] RI_CNT   = 3'd6;
    localparam logic [2:0] RI_PARA  = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_FWAIT, S_CHECK, S_RD, S_RWAIT, S_WR, S_END
    } seq_state_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } mem_cmd_t;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    width_bytes = 3'd1;
            2'd1:    width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmac_addr_gen.sv
module dmac_addr_gen
    import dmac_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    input  logic          fixed,
    input  logic [1:0]    width,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] step;
    assign step = AW'(width_bytes(width));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step_en && !fixed) begin
            addr <= addr + step;
        end
    end

    // R6
    fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && fixed) |=> (addr == $past(addr)));

    // R6
    no_step_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_en) |=> $stable(addr));

endmodule

// File: rtl/dmac_byte_count.sv
module dmac_byte_count #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          beat,
    input  logic [2:0]    step,
    output logic [CW-1:0] cnt,
    output logic          cnt_zero,
    output logic          half_pulse
);

    logic [CW-1:0] len_q;
    logic          fired_q;
    logic [CW-1:0] step_w;
    logic [CW-1:0] cnt_nxt;
    logic          half_hit;

    assign step_w   = CW'(step);
    assign cnt_nxt  = (cnt > step_w) ? (cnt - step_w) : '0;
    assign half_hit = ({cnt_nxt, 1'b0} <= {1'b0, len_q});
    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            len_q      <= '0;
            fired_q    <= 1'b0;
            half_pulse <= 1'b0;
        end else begin
            half_pulse <= 1'b0;
            if (load) begin
                cnt     <= load_val;
                len_q   <= load_val;
                fired_q <= 1'b0;
            end else if (beat) begin
                cnt <= cnt_nxt;
                if (!fired_q && half_hit) begin
                    half_pulse <= 1'b1;
                    fired_q    <= 1'b1;
                end
            end
        end
    end

    // R7
    count_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt <= $past(cnt)));

    // R9
    half_single_chk: assert property (@(posedge clk) disable iff (rst)
        half_pulse |=> !half_pulse);

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 stop,
    input  logic                 paused,
    input  logic [WORD_W-1:0]    first_addr,
    input  logic [NUM_LINES-1:0] drq,
    input  logic                 src_fixed,
    input  logic [4:0]           src_line,
    input  logic                 dst_fixed,
    input  logic [4:0]           dst_line,
    input  logic                 cnt_zero,
    input  logic [WORD_W-1:0]    src_addr,
    input  logic [WORD_W-1:0]    dst_addr,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    output mem_cmd_t             cmd,
    output logic                 busy,
    output logic                 word_load,
    output logic [2:0]           word_idx,
    output logic                 beat_done,
    output logic                 evt_pkg,
    output logic                 evt_queue
);

    seq_state_t        state_q;
    logic [2:0]        idx_q;
    logic [WORD_W-1:0] daddr_q;
    logic [WORD_W-1:0] next_q;
    logic [WORD_W-1:0] buf_q;
    logic              src_ok;
    logic              dst_ok;
    logic              accepted;
    logic              last_desc;

    function automatic logic line_hit(input logic [NUM_LINES-1:0] v,
                                      input logic [4:0] ln);
        line_hit = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ln == 5'(i)) line_hit = v[i];
        end
    endfunction

    assign src_ok = !src_fixed || line_hit(drq, src_line);
    assign dst_ok = !dst_fixed || line_hit(drq, dst_line);

    always_comb begin
        cmd = '0;
        case (state_q)
            S_FETCH: begin
                cmd.req  = !paused;
                cmd.addr = daddr_q + {27'd0, idx_q, 2'b00};
            end
            S_RD: begin
                cmd.req  = !paused && src_ok;
                cmd.addr = src_addr;
            end
            S_WR: begin
                cmd.req   = !paused && dst_ok;
                cmd.we    = 1'b1;
                cmd.addr  = dst_addr;
                cmd.wdata = buf_q;
            end
            default: cmd = '0;
        endcase
    end

    assign accepted  = cmd.req && mem_gnt;
    assign word_load = (state_q == S_FWAIT) && mem_rvalid;
    assign word_idx  = idx_q;
    assign beat_done = (state_q == S_WR) && accepted;
    assign last_desc = (next_q == CHAIN_END);
    assign evt_pkg   = (state_q == S_END);
    assign evt_queue = (state_q == S_END) && last_desc;
    assign busy      = (state_q != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            daddr_q <= '0;
            next_q  <= '0;
            buf_q   <= '0;
        end else if (stop) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    daddr_q <= first_addr;
                    idx_q   <= '0;
                    state_q <= S_FETCH;
                end
                S_FETCH: if (accepted) state_q <= S_FWAIT;
                S_FWAIT: if (mem_rvalid) begin
                    if (idx_q == W_NEXT) begin
                        next_q  <= mem_rdata;
                        state_q <= S_CHECK;
                    end else begin
                        idx_q   <= idx_q + 3'd1;
                        state_q <= S_FETCH;
                    end
                end
                S_CHECK: state_q <= cnt_zero ? S_END : S_RD;
                S_RD: if (accepted) state_q <= S_RWAIT;
                S_RWAIT: if (mem_rvalid) begin
                    buf_q   <= mem_rdata;
                    state_q <= S_WR;
                end
                S_WR: if (accepted) state_q <= S_CHECK;
                S_END: begin
                    if (last_desc) begin
                        state_q <= S_IDLE;
                    end else begin
                        daddr_q <= next_q;
                        idx_q   <= '0;
                        state_q <= S_FETCH;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R8
    pkg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        evt_pkg |=> !evt_pkg);

    // R10
    pause_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (paused && !stop && (state_q == S_RD || state_q == S_WR || state_q == S_FETCH))
            |=> (state_q == $past(state_q)));

endmodule

// File: rtl/dmac_ll_channel.sv
module dmac_ll_channel
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [2:0]           reg_idx,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] drq,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [31:0]          mem_rdata,
    output logic                 evt_half,
    output logic                 evt_pkg,
    output logic                 evt_queue
);

    logic [WORD_W-1:0] first_q;
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] para_q;
    logic              pause_q;
    logic              busy;
    logic              start_cmd;
    logic              stop_cmd;
    logic              word_load;
    logic [2:0]        word_idx;
    logic              beat_done;
    logic              cnt_zero;
    logic [WORD_W-1:0] cnt;
    logic [WORD_W-1:0] src_addr;
    logic [WORD_W-1:0] dst_addr;
    mem_cmd_t          cmd;

    // per-side fields decoded from the live config word
    logic [4:0] side_line  [2];
    logic       side_fixed [2];
    logic [1:0] side_width [2];
    logic       side_load  [2];
    logic [WORD_W-1:0] side_addr [2];

    assign start_cmd = reg_we && (reg_idx == RI_RUN) && reg_wdata[0] && !busy;
    assign stop_cmd  = reg_we && (reg_idx == RI_RUN) && !reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            cfg_q   <= '0;
            para_q  <= '0;
            pause_q <= 1'b0;
        end else begin
            if (reg_we && reg_idx == RI_FIRST) first_q <= reg_wdata;
            if (reg_we && reg_idx == RI_PAUSE) pause_q <= reg_wdata[1];
            if (word_load && word_idx == W_CFG)  cfg_q  <= mem_rdata;
            if (word_load && word_idx == W_PARA) para_q <= mem_rdata;
        end
    end

    // side 0 = source (low half), side 1 = destination (high half)
    for (genvar s = 0; s < 2; s++) begin : g_side
        assign side_line[s]  = cfg_q[16*s +: 5];
        assign side_fixed[s] = cfg_q[16*s + 5];
        assign side_width[s] = cfg_q[16*s + 9 +: 2];
        assign side_load[s]  = word_load && (word_idx == (s == 0 ? W_SRC : W_DST));

        dmac_addr_gen #(.AW(WORD_W)) u_addr (
            .clk      (clk),
            .rst      (rst),
            .load     (side_load[s]),
            .load_val (mem_rdata),
            .step_en  (beat_done),
            .fixed    (side_fixed[s]),
            .width    (side_width[s]),
            .addr     (side_addr[s])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];

    dmac_byte_count #(.CW(WORD_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (word_load && word_idx == W_LEN),
        .load_val   (mem_rdata),
        .beat       (beat_done),
        .step       (width_bytes(side_width[0])),
        .cnt        (cnt),
        .cnt_zero   (cnt_zero),
        .half_pulse (evt_half)
    );

    dmac_seq #(.NUM_LINES(NUM_LINES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_cmd),
        .stop       (stop_cmd),
        .paused     (pause_q),
        .first_addr (first_q),
        .drq        (drq),
        .src_fixed  (side_fixed[0]),
        .src_line   (side_line[0]),
        .dst_fixed  (side_fixed[1]),
        .dst_line   (side_line[1]),
        .cnt_zero   (cnt_zero),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .cmd        (cmd),
        .busy       (busy),
        .word_load  (word_load),
        .word_idx   (word_idx),
        .beat_done  (beat_done),
        .evt_pkg    (evt_pkg),
        .evt_queue  (evt_queue)
    );

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;

    always_comb begin
        case (reg_idx)
            RI_RUN:   reg_rdata = {31'd0, busy};
            RI_PAUSE: reg_rdata = {30'd0, pause_q, 1'b0};
            RI_FIRST: reg_rdata = first_q;
            RI_CFG:   reg_rdata = cfg_q;
            RI_SRC:   reg_rdata = src_addr;
            RI_DST:   reg_rdata = dst_addr;
            RI_CNT:   reg_rdata = cnt;
            default:  reg_rdata = para_q;
        endcase
    end

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> (!busy && !mem_req));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_cmd |=> busy);

    // R4
    queue_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_queue && !stop_cmd) |=> !busy);

    // R13
    cnt_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_load && !beat_done) |=> $stable(cnt));

endmodule

// File: tb/tb_dmac_ll_channel.sv
module tb_dmac_ll_channel;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] END_MARK = 32'hFFFF_F800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd6;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] drq = '0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rvalid;
    logic        evt_half, evt_pkg, evt_queue;

    logic [31:0] mem [0:255];
    int errors = 0, checks = 0;
    int wr_n = 0, rd_n = 0, req_cycles = 0;
    int pkg_n = 0, queue_n = 0, half_n = 0;
    logic [31:0] half_cnt = '0, last_wr_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_ll_channel dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drq(drq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .evt_half(evt_half), .evt_pkg(evt_pkg),
        .evt_queue(evt_queue)
    );

    assign mem_gnt = mem_req;

    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i;
    end

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) req_cycles <= req_cycles + 1;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                wr_n <= wr_n + 1;
                last_wr_addr <= mem_addr;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:2]];
                rd_n <= rd_n + 1;
            end
        end
        if (evt_pkg)   pkg_n   <= pkg_n + 1;
        if (evt_queue) queue_n <= queue_n + 1;
        if (evt_half) begin
            half_n   <= half_n + 1;
            half_cnt <= reg_rdata;
        end
    end

    function automatic logic [31:0] orig(input int w);
        orig = 32'hC0DE_0000 + w;
    endfunction

    function automatic logic [31:0] mk_cfg(input logic [4:0] sl, input logic sf,
        input logic [1:0] sw, input logic [4:0] dl, input logic df, input logic [1:0] dw);
        logic [15:0] s, d;
        s = {5'd0, sw, 2'd0, 1'b0, sf, sl};
        d = {5'd0, dw, 2'd0, 1'b0, df, dl};
        mk_cfg = {d, s};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_idx = 3'd6;
    endtask

    task automatic reg_read(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
        reg_idx = 3'd6;
    endtask

    task automatic put_desc(input int b, input logic [31:0] cfg, input logic [31:0] src,
        input logic [31:0] dst, input logic [31:0] len, input logic [31:0] para,
        input logic [31:0] nxt);
        mem[b] = cfg; mem[b+1] = src; mem[b+2] = dst;
        mem[b+3] = len; mem[b+4] = para; mem[b+5] = nxt;
    endtask

    task automatic run_chain(input logic [31:0] first);
        reg_write(3'd2, first);
        reg_write(3'd0, 32'd1);
    endtask

    task automatic wait_queue(input int q0, input int maxc);
        for (int i = 0; i < maxc && queue_n == q0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic wait_wr(input int n);
        for (int i = 0; i < 500 && wr_n < n; i++) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int r = 0; r < 8; r++) begin
            reg_read(3'(r), d);
            chk_eq($sformatf("R1 reset reg %0d", r), d, 32'd0);
        end
        chk_eq("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk_eq("R1 reset events", pkg_n + queue_n + half_n, 32'd0);
        reg_write(3'd2, 32'h0000_0ABC);
        reg_read(3'd2, d);
        chk_eq("R1 first address readback", d, 32'h0000_0ABC);
    endtask

    task automatic t_single();
        logic [31:0] d;
        int q0 = queue_n, p0 = pkg_n, h0 = half_n, w0 = wr_n, r0 = rd_n;
        put_desc(0, mk_cfg(5'd1, 1'b0, 2'd2, 5'd1, 1'b0, 2'd2),
                 32'h200, 32'h300, 32'd16, 32'd8, END_MARK);
        run_chain(32'h0);
        reg_read(3'd0, d);
        chk_eq("R2 run reads 1 while active", d, 32'd1);
        wait_queue(q0, 400);
        for (int i = 0; i < 4; i++)
            chk_eq($sformatf("R3 single dst word %0d", i), mem[8'hC0 + i], orig(8'h80 + i));
        chk_eq("R3 read requests fetch+data", rd_n - r0, 32'd10);
        chk_eq("R7 write beats", wr_n - w0, 32'd4);
        chk_eq("R8 pkg pulses", pkg_n - p0, 32'd1);
        chk_eq("R8 queue pulses", queue_n - q0, 32'd1);
        chk_eq("R9 half pulses", half_n - h0, 32'd1);
        chk_eq("R9 count at half pulse", half_cnt, 32'd8);
        reg_read(3'd4, d); chk_eq("R6 src final", d, 32'h210);
        reg_read(3'd5, d); chk_eq("R6 dst final", d, 32'h310);
        reg_read(3'd6, d); chk_eq("R7 count final", d, 32'd0);
        reg_read(3'd3, d); chk_eq("R3 cfg loaded", d, mk_cfg(5'd1, 1'b0, 2'd2, 5'd1, 1'b0, 2'd2));
        reg_read(3'd7, d); chk_eq("R3 para loaded", d, 32'd8);
        reg_read(3'd0, d); chk_eq("R4 idle after chain", d, 32'd0);
    endtask

    task automatic t_chain();
        int q0 = queue_n, p0 = pkg_n, h0 = half_n, w0 = wr_n;
        logic [31:0] c = mk_cfg(5'd0, 1'b0, 2'd2, 5'd0, 1'b0, 2'd2);
        put_desc(16'h10, c, 32'h220, 32'h320, 32'd8, 32'd0, 32'h060);
        put_desc(16'h18, c, 32'h2F0, 32'h3F0, 32'd0, 32'd0, 32'h080);
        put_desc(16'h20, c, 32'h230, 32'h330, 32'd4, 32'd0, END_MARK);
        run_chain(32'h040);
        wait_queue(q0, 800);
        chk_eq("R4 chain word a", mem[8'hC8], orig(8'h88));
        chk_eq("R4 chain word b", mem[8'hC9], orig(8'h89));
        chk_eq("R4 chain word c", mem[8'hCC], orig(8'h8C));
        chk_eq("R11 zero-length moves nothing", mem[8'hFC], orig(8'hFC));
        chk_eq("R11 pkg per descriptor", pkg_n - p0, 32'd3);
        chk_eq("R4 single queue pulse", queue_n - q0, 32'd1);
        chk_eq("R9 half per nonzero descriptor", half_n - h0, 32'd2);
        chk_eq("R7 chain beats", wr_n - w0, 32'd3);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        int q0 = queue_n, w0 = wr_n;
        drq = 32'h0000_0008;
        put_desc(16'h28, mk_cfg(5'd0, 1'b0, 2'd0, 5'd3, 1'b1, 2'd2),
                 32'h240, 32'h340, 32'd3, 32'd0, END_MARK);
        run_chain(32'h0A0);
        wait_queue(q0, 400);
        chk_eq("R5 byte width beats", wr_n - w0, 32'd3);
        chk_eq("R6 fixed dst write address", last_wr_addr, 32'h340);
        chk_eq("R6 fixed dst data", mem[8'hD0], orig(8'h90));
        reg_read(3'd4, d); chk_eq("R6 src steps by 1", d, 32'h243);
        reg_read(3'd5, d); chk_eq("R6 fixed dst holds", d, 32'h340);
        drq = '0;
    endtask

    task automatic t_drq();
        logic [31:0] d;
        int q0 = queue_n, w0 = wr_n, r0 = rd_n;
        put_desc(16'h30, mk_cfg(5'd5, 1'b1, 2'd2, 5'd0, 1'b0, 2'd2),
                 32'h250, 32'h350, 32'd8, 32'd0, END_MARK);
        run_chain(32'h0C0);
        repeat (40) @(posedge clk);
        chk_eq("R12 only fetch reads without drq", rd_n - r0, 32'd6);
        chk_eq("R12 no writes without drq", wr_n - w0, 32'd0);
        @(negedge clk) drq = 32'h0000_0020;
        wait_queue(q0, 400);
        chk_eq("R12 beats after drq", wr_n - w0, 32'd2);
        chk_eq("R12 fixed src data", mem[8'hD5], orig(8'h94));
        reg_read(3'd4, d); chk_eq("R12 fixed src holds", d, 32'h250);
        reg_read(3'd5, d); chk_eq("R12 dst advanced", d, 32'h358);
        drq = '0;
    endtask

    task automatic t_pause();
        logic [31:0] c0, c1;
        int q0 = queue_n, w0 = wr_n, rq0;
        put_desc(16'h38, mk_cfg(5'd0, 1'b0, 2'd2, 5'd0, 1'b0, 2'd2),
                 32'h260, 32'h360, 32'd32, 32'd0, END_MARK);
        run_chain(32'h0E0);
        wait_wr(w0 + 2);
        reg_write(3'd1, 32'h2);
        repeat (4) @(posedge clk);
        rq0 = req_cycles;
        reg_read(3'd6, c0);
        repeat (30) @(posedge clk);
        reg_read(3'd6, c1);
        chk_eq("R10 no requests while paused", req_cycles - rq0, 32'd0);
        chk_eq("R10 count holds while paused", c1, c0);
        reg_write(3'd1, 32'h0);
        wait_queue(q0, 800);
        chk_eq("R10 resumed beats", wr_n - w0, 32'd8);
        chk_eq("R10 last word", mem[8'hDF], orig(8'h9F));
    endtask

    task automatic t_stop();
        logic [31:0] d;
        int p0 = pkg_n, q0 = queue_n, w1, rq0;
        put_desc(16'h40, mk_cfg(5'd0, 1'b0, 2'd2, 5'd0, 1'b0, 2'd2),
                 32'h280, 32'h380, 32'd32, 32'd0, END_MARK);
        run_chain(32'h100);
        wait_wr(wr_n + 2);
        reg_write(3'd0, 32'd0);
        w1 = wr_n;
        rq0 = req_cycles;
        reg_read(3'd0, d);
        chk_eq("R2 idle after stop", d, 32'd0);
        repeat (30) @(posedge clk);
        chk_eq("R2 no requests after stop", req_cycles - rq0, 32'd0);
        chk_eq("R2 no writes after stop", wr_n - w1, 32'd0);
        chk_eq("R2 no events after stop", (pkg_n - p0) + (queue_n - q0), 32'd0);
    endtask

    task automatic t_readonly();
        logic [31:0] b, a;
        for (int r = 3; r < 8; r++) begin
            reg_read(3'(r), b);
            reg_write(3'(r), ~b);
            reg_read(3'(r), a);
            chk_eq($sformatf("R13 reg %0d ignores write", r), a, b);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_chain();
        t_fixed();
        t_drq();
        t_pause();
        t_stop();
        t_readonly();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule